// File: doc/BRIEF.md
# Configuration Stream Payload Extractor

This block sits between a source of raw configuration files and a serial loader. It takes the file in as a stream of bytes with a valid/ready handshake and a last flag. The file starts with a header. The block drops the whole header and sends on only the configuration payload. The header has two parts. First comes a prefix of fixed length. After it come several text fields, each of which starts with a length byte. The block never stores or interprets the field text. It only uses each length byte to find where the next field begins.

Once the header is behind it, the block looks for a sync preamble, which is a run of consecutive 0xFF bytes. The first byte of that run marks the start of the payload. From there on, every byte is forwarded unchanged through the end of the file. The block counts the payload bytes it forwards and reports the total once the final byte has been taken downstream. If the file ends before a preamble is found, a header error flag is raised and nothing is forwarded. After each file the block returns to its start state, ready for the next file on the same stream.

Top module: `cfg_payload_extract`

## Requirements
- R1: After reset, in_ready is 1, and out_valid, hdr_err, count_valid and byte_count are all 0.
- R2: The first PREFIX_LEN bytes of a file (default 15) are accepted and discarded whatever their values are, including 0xFF.
- R3: After the prefix, NUM_FIELDS (default 4) fields are walked. The byte at the start of a field holds its length L. The next field, or the preamble search once the last field is done, begins L+FIELD_GAP bytes (default L+3) after that length byte. Every byte in this region is discarded, including 0xFF bytes.
- R4: After the fields, bytes are checked one at a time. The preamble is SYNC_LEN (default 4) consecutive bytes equal to 0xFF. Any other byte clears the run count to zero and is discarded, with no look-back.
- R5: The first SYNC_LEN bytes of a payload are 0xFF. In a run of more than SYNC_LEN 0xFF bytes, the payload starts at the first byte of the run, and the extra 0xFF bytes are forwarded as payload.
- R6: While a run is shorter than SYNC_LEN, its bytes are held back and no output is produced. When the last byte of the run is accepted, input stalls, and SYNC_LEN 0xFF bytes are sent out in order.
- R7: Every byte after the preamble is forwarded unchanged and in order, up to and including the byte marked last, with out_last set only on that final byte. Data are never lost or duplicated under backpressure on either side.
- R8: If in_last arrives on a header byte or during the preamble search, hdr_err rises in the next cycle, no output is produced for that file, and hdr_err and count_valid are never 1 together.
- R9: byte_count increases by one for each output handshake. In the cycle after the handshake that carries out_last, count_valid is 1 and byte_count equals the number of payload bytes, preamble included.
- R10: When the first byte of the next file is accepted, hdr_err, count_valid and byte_count are cleared, and that file is processed from its prefix.
- R11: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data stays stable into the next cycle, as long as the upstream side holds its own valid byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts the input byte |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the last byte of the file |
| out_valid | output | 1 | Payload byte valid |
| out_ready | input | 1 | Downstream accepts the payload byte |
| out_data | output | 8 | Payload byte |
| out_last | output | 1 | Payload byte is the last byte of the file |
| hdr_err | output | 1 | File ended before a preamble was found; held until the next file starts |
| count_valid | output | 1 | byte_count holds the final payload total; held until the next file starts |
| byte_count | output | CNT_W | Payload bytes forwarded so far in this file |

## Verification
Suppose the skip counter or the field counter holds a wrong value. The preamble search then starts at the wrong byte. That shows up at the ports on the first preamble byte: a header byte equal to 0xFF is let through, or a real run is missed, and the payload either starts early or hdr_err is raised. An error in the run count changes the number of leading 0xFF bytes emitted, or lets a broken run through. This shows within SYNC_LEN bytes of the search position, and also in the final byte_count. Files whose header bytes are all 0xFF, whose field lengths vary, and whose fake runs stop at three 0xFF bytes separate these faults cleanly.

// File: rtl/cfg_payload_extract.sv
module cfg_payload_extract #(
  parameter int PREFIX_LEN = 15,
  parameter int NUM_FIELDS = 4,
  parameter int FIELD_GAP  = 3,
  parameter int SYNC_LEN   = 4,
  parameter logic [7:0] SYNC_BYTE = 8'hFF,
  parameter int CNT_W      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic             hdr_err,
  output logic             count_valid,
  output logic [CNT_W-1:0] byte_count
);
  localparam int PFX_W  = $clog2(PREFIX_LEN + 1);
  localparam int SKIP_W = (PFX_W > 10) ? PFX_W : 10;
  localparam int FLD_W  = $clog2(NUM_FIELDS + 1);
  localparam int RUN_W  = $clog2(SYNC_LEN + 1);

  typedef enum logic [2:0] {ST_SKIP, ST_LEN, ST_HUNT, ST_FLUSH, ST_PASS} st_t;

  st_t              st;
  logic [SKIP_W-1:0] skip_cnt;
  logic [FLD_W-1:0]  fld_cnt;
  logic [RUN_W-1:0]  run_cnt;
  logic              last_hold;

  wire in_fire    = in_valid && in_ready;
  wire out_fire   = out_valid && out_ready;
  wire is_sync    = in_data == SYNC_BYTE;
  wire file_start = st == ST_SKIP && fld_cnt == '0 && skip_cnt == SKIP_W'(PREFIX_LEN);
  wire [SKIP_W-1:0] skip_load = SKIP_W'(in_data) + SKIP_W'(FIELD_GAP - 1);
  wire [FLD_W-1:0]  fld_next  = fld_cnt + 1'b1;
  wire              fld_done  = fld_next == FLD_W'(NUM_FIELDS);
  wire              skip_done = fld_cnt == FLD_W'(NUM_FIELDS);

  assign in_ready  = (st == ST_PASS) ? out_ready : (st != ST_FLUSH);
  assign out_valid = (st == ST_PASS) ? in_valid  : (st == ST_FLUSH);
  assign out_data  = (st == ST_PASS) ? in_data   : SYNC_BYTE;
  assign out_last  = (st == ST_PASS) ? in_last   : (last_hold && run_cnt == RUN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_SKIP;
      skip_cnt    <= SKIP_W'(PREFIX_LEN);
      fld_cnt     <= '0;
      run_cnt     <= '0;
      last_hold   <= 1'b0;
      hdr_err     <= 1'b0;
      count_valid <= 1'b0;
      byte_count  <= '0;
    end else begin
      if (in_fire && file_start) begin
        hdr_err     <= 1'b0;
        count_valid <= 1'b0;
        byte_count  <= '0;
      end
      if (out_fire) byte_count <= byte_count + 1'b1;
      if (out_fire && out_last) begin
        count_valid <= 1'b1;
        st          <= ST_SKIP;
        skip_cnt    <= SKIP_W'(PREFIX_LEN);
        fld_cnt     <= '0;
        run_cnt     <= '0;
      end
      case (st)
        ST_SKIP: if (in_fire) begin
          if (in_last) begin
            hdr_err  <= 1'b1;
            skip_cnt <= SKIP_W'(PREFIX_LEN);
            fld_cnt  <= '0;
          end else if (skip_cnt == SKIP_W'(1)) begin
            st <= skip_done ? ST_HUNT : ST_LEN;
          end else begin
            skip_cnt <= skip_cnt - 1'b1;
          end
        end
        ST_LEN: if (in_fire) begin
          if (in_last) begin
            hdr_err  <= 1'b1;
            st       <= ST_SKIP;
            skip_cnt <= SKIP_W'(PREFIX_LEN);
            fld_cnt  <= '0;
          end else begin
            fld_cnt <= fld_next;
            if (skip_load == '0) begin
              st <= fld_done ? ST_HUNT : ST_LEN;
            end else begin
              skip_cnt <= skip_load;
              st       <= ST_SKIP;
            end
          end
        end
        ST_HUNT: if (in_fire) begin
          if (is_sync && run_cnt == RUN_W'(SYNC_LEN - 1)) begin
            st        <= ST_FLUSH;
            run_cnt   <= RUN_W'(SYNC_LEN);
            last_hold <= in_last;
          end else if (in_last) begin
            hdr_err  <= 1'b1;
            st       <= ST_SKIP;
            skip_cnt <= SKIP_W'(PREFIX_LEN);
            fld_cnt  <= '0;
            run_cnt  <= '0;
          end else begin
            run_cnt <= is_sync ? run_cnt + 1'b1 : '0;
          end
        end
        ST_FLUSH: if (out_fire) begin
          run_cnt <= run_cnt - 1'b1;
          if (run_cnt == RUN_W'(1) && !last_hold) st <= ST_PASS;
        end
        default: ;
      endcase
    end
  end
endmodule

module cfg_payload_extract_chk #(
  parameter int SYNC_LEN = 4,
  parameter int CNT_W    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_last,
  input logic             hdr_err,
  input logic             count_valid,
  input logic [CNT_W-1:0] byte_count
);
  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> byte_count == $past(byte_count) + 1'b1);

  assert_count_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(count_valid) |-> $past(out_valid && out_ready && out_last));

  assert_preamble_lead_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !count_valid && byte_count < CNT_W'(SYNC_LEN)) |-> out_data == 8'hFF);

  assert_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(hdr_err && count_valid));

  assert_err_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |-> !out_valid);

  assert_stall_reason_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && in_valid) |-> out_valid);

  assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && in_valid && !in_ready) |=> out_valid && $stable(out_data));
endmodule

bind cfg_payload_extract cfg_payload_extract_chk #(.SYNC_LEN(SYNC_LEN), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
  .hdr_err(hdr_err), .count_valid(count_valid), .byte_count(byte_count)
);

// File: tb/cfg_payload_extract_tb_top.sv
module cfg_payload_extract_tb_top;
  localparam int CNT_W = 32;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, out_valid, out_last, hdr_err, count_valid;
  logic [7:0] out_data;
  logic [CNT_W-1:0] byte_count;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int rdy_pct = 75;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cfg_payload_extract dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .hdr_err(hdr_err),
    .count_valid(count_valid), .byte_count(byte_count)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void model(input byte unsigned f[$], output byte unsigned p[$], output bit err);
    int idx = 15;
    p = {};
    err = 1'b1;
    for (int k = 0; k < 4; k++) begin
      if (idx >= f.size()) return;
      idx += int'(f[idx]) + 3;
    end
    for (int i = idx; i + 3 < f.size(); i++) begin
      if (f[i] == 8'hFF && f[i+1] == 8'hFF && f[i+2] == 8'hFF && f[i+3] == 8'hFF) begin
        for (int j = i; j < f.size(); j++) p.push_back(f[j]);
        err = 1'b0;
        return;
      end
    end
  endfunction

  function automatic byte unsigned rbyte(input int ff_pct);
    return ($urandom % 100 < ff_pct) ? 8'hFF : 8'($urandom);
  endfunction

  task automatic add_hdr(ref byte unsigned f[$], input int pfx_ff, input int max_len);
    for (int i = 0; i < 15; i++) f.push_back(rbyte(pfx_ff));
    for (int k = 0; k < 4; k++) begin
      int l = $urandom % (max_len + 1);
      f.push_back(8'(l));
      for (int j = 0; j < l + 2; j++) f.push_back(rbyte(pfx_ff));
    end
  endtask

  task automatic run_file(input byte unsigned f[$], input string tag);
    byte unsigned exp_p[$], got[$];
    bit exp_err, got_last, fired, done;
    int idx = 0, lasts = 0, last_pos = -1;
    model(f, exp_p, exp_err);
    fired = 1'b0;
    got_last = 1'b0;
    done = 1'b0;
    while (!done) begin
      @(negedge clk);
      if (fired || !in_valid) in_valid = (idx < f.size()) && ($urandom % 4 != 0);
      if (idx < f.size()) begin
        in_data = f[idx];
        in_last = (idx == f.size() - 1);
      end
      out_ready = ($urandom % 100) < rdy_pct;
      #1;
      fired = in_valid && in_ready;
      if (out_valid && out_ready) begin
        got.push_back(out_data);
        if (out_last) begin lasts++; last_pos = got.size() - 1; got_last = 1'b1; end
      end
      if (fired) begin
        idx++;
        if (idx == 1) begin
          @(negedge clk);
          chk(!hdr_err && !count_valid && byte_count == 0, "R10", {tag, " flags cleared at file start"},
              {hdr_err, count_valid}, 0);
          in_valid = 1'b0;
          fired = 1'b0;
        end
      end
      done = exp_err ? (idx == f.size()) : got_last;
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b0;
    #1;
    if (exp_err) begin
      chk(hdr_err == 1'b1, "R8", {tag, " hdr_err"}, hdr_err, 1);
      chk(got.size() == 0, "R8", {tag, " output bytes on error"}, got.size(), 0);
      chk(!count_valid, "R8", {tag, " count_valid on error"}, count_valid, 0);
    end else begin
      bit same = got.size() == exp_p.size();
      for (int i = 0; same && i < got.size(); i++) same = got[i] == exp_p[i];
      chk(same, "R7", {tag, " payload bytes (size)"}, got.size(), exp_p.size());
      chk(exp_p.size() >= 4 && got.size() >= 4 && got[0] == 8'hFF && got[3] == 8'hFF,
          "R5", {tag, " leading sync bytes"}, got.size() > 0 ? got[0] : -1, 255);
      chk(lasts == 1 && last_pos == exp_p.size() - 1, "R7", {tag, " out_last position"},
          last_pos, exp_p.size() - 1);
      chk(count_valid && byte_count == exp_p.size(), "R9", {tag, " byte_count"},
          byte_count, exp_p.size());
      chk(!hdr_err, "R8", {tag, " no hdr_err"}, hdr_err, 0);
    end
  endtask

  initial begin
    #(LIMIT * 10);
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, LIMIT);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    byte unsigned f[$];
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    chk(in_ready && !out_valid && !hdr_err && !count_valid && byte_count == 0, "R1",
        "reset outputs", {in_ready, out_valid, hdr_err, count_valid}, 4'b1000);
    rst_n = 1'b1;

    // R2, R3: header all 0xFF with zero-length fields, preamble immediately after
    f = {};
    for (int i = 0; i < 15; i++) f.push_back(8'hFF);
    for (int k = 0; k < 4; k++) begin f.push_back(8'h00); f.push_back(8'hFF); f.push_back(8'hFF); end
    f = {f, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h12, 8'h34, 8'h56};
    run_file(f, "R2_R3_ff_header");

    // R4, R6: broken runs of three before the real preamble
    f = {};
    add_hdr(f, 0, 5);
    f = {f, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'h7E, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hA5};
    run_file(f, "R4_R6_broken_runs");

    // R5: long run of 0xFF starts payload at its first byte
    f = {};
    add_hdr(f, 30, 8);
    f = {f, 8'h01, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'hFF};
    run_file(f, "R5_long_run");

    // R6: file ends on the last preamble byte
    f = {};
    add_hdr(f, 0, 3);
    f = {f, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    run_file(f, "R6_end_on_sync");

    // R8: no preamble
    f = {};
    add_hdr(f, 0, 3);
    f = {f, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h55};
    run_file(f, "R8_no_sync");

    // R8: file ends inside the header
    f = {};
    for (int i = 0; i < 9; i++) f.push_back(8'hFF);
    run_file(f, "R8_short_header");

    // R11: heavy backpressure
    rdy_pct = 20;
    f = {};
    add_hdr(f, 10, 6);
    f = {f, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    for (int i = 0; i < 24; i++) f.push_back(8'($urandom));
    run_file(f, "R11_backpressure");

    for (int n = 0; n < 40; n++) begin
      rdy_pct = 30 + ($urandom % 71);
      f = {};
      add_hdr(f, $urandom % 40, 12);
      for (int i = 0; i < int'($urandom % 10); i++) f.push_back(rbyte(60));
      if ($urandom % 8 != 0) begin
        f = {f, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
        for (int i = 0; i < int'($urandom % 30); i++) f.push_back(rbyte(20));
      end
      run_file(f, "R7_random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule